// File: doc/BRIEF.md
# Zero-Skipping Tiled Convolution Engine

This block builds one 4x4 output tile of a convolution layer and keeps it in place until it is complete. Upstream logic first hands it the four input tiles around the output position: the tile aligned with the output, the tile to its right, the tile below, and the tile below and to the right. It then streams the non-zero weights of the filter tile. Each weight carries the 4-bit position it held inside its 4x4 weight tile. Weights of value zero are dropped before they reach the block, so they cost no cycles.

For each accepted weight, all sixteen output positions pick their input value from the 8x8 area formed by the four input tiles. The weight's position shifts that 4x4 window. Each output position multiplies its input value by the weight and adds the product into its own full-width accumulator. After the beat flagged as last, the sixteen sums appear on the result stream. When the result is taken, the accumulators are cleared and the block asks for the next four tiles.

Top module: `zsc_engine`

## Requirements
- R1: After reset, tin_ready is 1, w_ready is 0 and acc_valid is 0.
- R2: Input tiles are accepted in this order: aligned, right, below, below-right. Value (r,c) of a tile sits at tin_data[(4r+c)*9 +: 9], with bit 8 as the sign and bits 7:0 as the magnitude. No weight is accepted before the fourth tile has been taken. tin_ready is 0 from the fourth tile until the result has been taken, so tiles offered in that time are ignored.
- R3: The weight position is split as w_offset[3:2]=oy and w_offset[1:0]=ox. The output at (r,c), carried on acc_data[(4r+c)*ACC_W +: ACC_W], adds weight times input value (r+oy, c+ox) of the 8x8 area. In that area, tile t covers rows 4*(t/2) to 4*(t/2)+3 and columns 4*(t%2) to 4*(t%2)+3.
- R4: Weights and input values are sign-magnitude numbers, and a negative zero acts as zero.
- R5: The sums are two's complement at ACC_W bits. They build up across any number of weight beats with no rounding or truncation.
- R6: A weight beat with w_empty=1 completes its handshake but leaves every sum unchanged.
- R7: The compute phase lasts at least four cycles. When n weights follow back to back from its first cycle, acc_valid is first 1 in the (max(n,4)+1)th cycle after the cycle in which the fourth tile was transferred.
- R8: acc_valid stays 1, with acc_data unchanged, until acc_ready is 1. After that transfer the sums read as zero and tin_ready returns to 1.
- R9: After the beat flagged w_last, w_ready stays 0 until the next position's four tiles have been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tin_valid | input | 1 | Input tile offered |
| tin_ready | output | 1 | Block accepts an input tile |
| tin_data | input | 144 | Sixteen sign-magnitude input values |
| w_valid | input | 1 | Weight beat offered |
| w_ready | output | 1 | Block accepts a weight beat |
| w_value | input | 9 | Sign-magnitude weight |
| w_offset | input | 4 | Weight position {oy, ox} |
| w_empty | input | 1 | Beat carries no weight |
| w_last | input | 1 | Final beat for this output tile |
| acc_valid | output | 1 | Result tile offered |
| acc_ready | input | 1 | Consumer takes the result |
| acc_data | output | 16*ACC_W | Sixteen two's complement sums |

## Verification
Four properties are checked on every cycle by the assertions:
- no weight is taken before all four tiles are held;
- the weight stream closes after the last beat;
- an empty beat leaves the sums unchanged, and a held result stays stable;
- the result never appears before four compute cycles, and the sums read as zero after a transfer.

Only the bench scenarios can show that each window shift selects the right input value. The same holds for sign handling, including negative zero, and for large sums across sixteen weights. The exact max(n,4) compute length is also shown there. The bench's own cycle model reaches this by comparing every handshake signal and every sum on every clock.

// File: rtl/zsc_pkg.sv
package zsc_pkg;
  localparam int MAG_W    = 8;
  localparam int SM_W     = MAG_W + 1;
  localparam int TILE_DIM = 4;
  localparam int TILE_N   = TILE_DIM * TILE_DIM;
  localparam int NTILES   = 4;
  localparam int TILE_W   = TILE_N * SM_W;
  localparam int REGION_W = NTILES * TILE_W;
  localparam int PROD_W   = 2 * MAG_W + 1;

  typedef enum logic [1:0] {ST_LOAD, ST_MAC, ST_OUT} zsc_state_t;

  // Signed product of two sign-magnitude numbers; negative zero yields zero.
  function automatic logic signed [PROD_W-1:0] sm_product(input logic [SM_W-1:0] a,
                                                          input logic [SM_W-1:0] b);
    logic [2*MAG_W-1:0] mag;
    logic signed [PROD_W-1:0] pos;
    mag = a[MAG_W-1:0] * b[MAG_W-1:0];
    pos = $signed({1'b0, mag});
    return (a[SM_W-1] ^ b[SM_W-1]) ? -pos : pos;
  endfunction

  // Slot of the 8x8 area seen by output (row,col) under shift (oy,ox):
  // {tile_y, tile_x, in-tile row, in-tile col}, i.e. tile*16 + value index.
  function automatic logic [5:0] win_slot(input logic [1:0] row, input logic [1:0] col,
                                          input logic [1:0] oy,  input logic [1:0] ox);
    logic [2:0] rr, cc;
    rr = {1'b0, row} + {1'b0, oy};
    cc = {1'b0, col} + {1'b0, ox};
    return {rr[2], cc[2], rr[1:0], cc[1:0]};
  endfunction
endpackage

// File: rtl/zsc_tile_store.sv
module zsc_tile_store
  import zsc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [TILE_W-1:0]   tile_i,
  input  logic                release_i,
  output logic                last_slot_o,
  output logic                full_o,
  output logic [REGION_W-1:0] region_o
);
  logic [1:0] slot_q;
  logic       full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q   <= '0;
      full_q   <= 1'b0;
      region_o <= '0;
    end else begin
      if (load_i) begin
        region_o[slot_q*TILE_W +: TILE_W] <= tile_i;
        slot_q <= slot_q + 2'd1;
        if (slot_q == 2'd3) full_q <= 1'b1;
      end
      if (release_i) full_q <= 1'b0;
    end
  end

  assign last_slot_o = (slot_q == 2'd3);
  assign full_o      = full_q;
endmodule

// File: rtl/zsc_lane.sv
module zsc_lane
  import zsc_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int ROW   = 0,
  parameter int COL   = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REGION_W-1:0] region_i,
  input  logic [SM_W-1:0]     weight_i,
  input  logic [3:0]          offset_i,
  input  logic                apply_i,
  input  logic                clear_i,
  output logic [ACC_W-1:0]    acc_o
);
  localparam logic [1:0] ROW_C = 2'(ROW);
  localparam logic [1:0] COL_C = 2'(COL);

  logic [5:0]                slot;
  logic [SM_W-1:0]           pick;
  logic signed [PROD_W-1:0]  prod;
  logic signed [ACC_W-1:0]   acc_q;

  assign slot = win_slot(ROW_C, COL_C, offset_i[3:2], offset_i[1:0]);
  assign pick = region_i[slot*SM_W +: SM_W];
  assign prod = sm_product(weight_i, pick);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) acc_q <= '0;
    else if (apply_i)      acc_q <= acc_q + ACC_W'(prod);
  end

  assign acc_o = acc_q;

  a_r8_cleared_after_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (acc_q == '0));
endmodule

// File: rtl/zsc_seq.sv
module zsc_seq
  import zsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tin_valid,
  input  logic last_slot_i,
  input  logic w_valid,
  input  logic w_last,
  input  logic acc_ready,
  output logic tin_ready,
  output logic w_ready,
  output logic acc_valid,
  output logic tin_fire,
  output logic w_fire,
  output logic out_fire
);
  zsc_state_t state_q;
  logic [1:0] span_q;
  logic       got_last_q;
  logic       end_mac;

  assign tin_ready = (state_q == ST_LOAD);
  assign w_ready   = (state_q == ST_MAC) && !got_last_q;
  assign acc_valid = (state_q == ST_OUT);
  assign tin_fire  = tin_valid && tin_ready;
  assign w_fire    = w_valid && w_ready;
  assign out_fire  = acc_valid && acc_ready;
  assign end_mac   = (state_q == ST_MAC) && (got_last_q || (w_fire && w_last))
                     && (span_q == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_LOAD;
      span_q     <= '0;
      got_last_q <= 1'b0;
    end else begin
      case (state_q)
        ST_LOAD: if (tin_fire && last_slot_i) begin
          state_q    <= ST_MAC;
          span_q     <= '0;
          got_last_q <= 1'b0;
        end
        ST_MAC: begin
          if (w_fire && w_last) got_last_q <= 1'b1;
          if (span_q != 2'd3)   span_q <= span_q + 2'd1;
          if (end_mac)          state_q <= ST_OUT;
        end
        ST_OUT: if (out_fire) state_q <= ST_LOAD;
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  a_r9_closed_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (w_fire && w_last) |=> !w_ready);
endmodule

// File: rtl/zsc_engine.sv
module zsc_engine
  import zsc_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tin_valid,
  output logic                  tin_ready,
  input  logic [TILE_W-1:0]     tin_data,
  input  logic                  w_valid,
  output logic                  w_ready,
  input  logic [SM_W-1:0]       w_value,
  input  logic [3:0]            w_offset,
  input  logic                  w_empty,
  input  logic                  w_last,
  output logic                  acc_valid,
  input  logic                  acc_ready,
  output logic [TILE_N*ACC_W-1:0] acc_data
);
  logic                tin_fire, w_fire, out_fire;
  logic                last_slot, tiles_full, apply;
  logic [REGION_W-1:0] region;

  zsc_seq u_seq (
    .clk, .rst_n, .tin_valid, .last_slot_i(last_slot), .w_valid, .w_last, .acc_ready,
    .tin_ready, .w_ready, .acc_valid, .tin_fire, .w_fire, .out_fire
  );

  zsc_tile_store u_store (
    .clk, .rst_n, .load_i(tin_fire), .tile_i(tin_data), .release_i(out_fire),
    .last_slot_o(last_slot), .full_o(tiles_full), .region_o(region)
  );

  assign apply = w_fire && !w_empty;

  for (genvar i = 0; i < TILE_N; i++) begin : g_lane
    zsc_lane #(.ACC_W(ACC_W), .ROW(i / TILE_DIM), .COL(i % TILE_DIM)) u_lane (
      .clk, .rst_n, .region_i(region), .weight_i(w_value), .offset_i(w_offset),
      .apply_i(apply), .clear_i(out_fire), .acc_o(acc_data[i*ACC_W +: ACC_W])
    );
  end

  // Cycles since the latest tile transfer, for the minimum-length check.
  logic [3:0] since_tile_q;
  always_ff @(posedge clk) begin
    if (!rst_n || tin_fire)                  since_tile_q <= '0;
    else if (!acc_valid && since_tile_q != 4'hF) since_tile_q <= since_tile_q + 4'd1;
  end

  a_r2_tiles_before_weights: assert property (@(posedge clk) disable iff (!rst_n)
    w_fire |-> tiles_full);
  a_r6_empty_keeps_sums: assert property (@(posedge clk) disable iff (!rst_n)
    (w_fire && w_empty) |=> $stable(acc_data));
  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_data)));
  a_r7_min_compute: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_valid) |-> (since_tile_q >= 4'd4));
endmodule

// File: tb/test_zsc_engine.sv
module test_zsc_engine;
  localparam int ACC_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tin_valid = 1'b0;
  logic [143:0] tin_data = '0;
  logic w_valid = 1'b0;
  logic [8:0] w_value = '0;
  logic [3:0] w_offset = '0;
  logic w_empty = 1'b0;
  logic w_last = 1'b0;
  logic acc_ready = 1'b0;
  logic tin_ready, w_ready, acc_valid;
  logic [16*ACC_W-1:0] acc_data;

  int checks = 0;
  int errors = 0;
  string cur_req = "R3";

  always #5 clk = ~clk;

  zsc_engine #(.ACC_W(ACC_W)) i_zsc_engine (
    .clk, .rst_n, .tin_valid, .tin_ready, .tin_data, .w_valid, .w_ready, .w_value,
    .w_offset, .w_empty, .w_last, .acc_valid, .acc_ready, .acc_data
  );

  function automatic logic [8:0] enc(input int v);
    return (v < 0) ? {1'b1, 8'(-v)} : {1'b0, 8'(v)};
  endfunction
  function automatic int dec(input logic [8:0] x);
    return x[8] ? -int'(x[7:0]) : int'(x[7:0]);
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 loading, 1 computing, 2 offering result.
  int m_phase = 0, m_ld = 0, m_cyc = 0;
  bit m_got = 0;
  int m_acc[16];
  logic [143:0] m_tile[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_ld = 0; m_cyc = 0; m_got = 0;
      foreach (m_acc[i]) m_acc[i] = 0;
    end else begin
      case (m_phase)
        0: if (tin_valid) begin
          m_tile[m_ld] = tin_data;
          if (m_ld == 3) begin m_phase = 1; m_cyc = 0; m_got = 0; end
          m_ld = (m_ld + 1) % 4;
        end
        1: begin
          bit take, fin;
          take = w_valid && !m_got;
          if (take && !w_empty) begin
            for (int r = 0; r < 4; r++) begin
              for (int c = 0; c < 4; c++) begin
                int rr, cc, t, v;
                rr = r + int'(w_offset[3:2]);
                cc = c + int'(w_offset[1:0]);
                t = (rr / 4) * 2 + (cc / 4);
                v = (rr % 4) * 4 + (cc % 4);
                m_acc[r*4+c] += dec(w_value) * dec(m_tile[t][v*9 +: 9]);
              end
            end
          end
          fin = (m_got || (take && w_last)) && (m_cyc == 3);
          if (take && w_last) m_got = 1;
          if (m_cyc < 3) m_cyc++;
          if (fin) m_phase = 2;
        end
        default: if (acc_ready) begin
          m_phase = 0;
          foreach (m_acc[i]) m_acc[i] = 0;
        end
      endcase
    end
  end

  bit run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      check("R2", int'(tin_ready), int'(m_phase == 0), "tin_ready");
      check("R9", int'(w_ready), int'(m_phase == 1 && !m_got), "w_ready");
      check("R7/R8", int'(acc_valid), int'(m_phase == 2), "acc_valid");
      if (m_phase == 2)
        for (int i = 0; i < 16; i++)
          check(cur_req, int'($signed(acc_data[i*ACC_W +: ACC_W])), m_acc[i],
                $sformatf("sum[%0d]", i));
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [8:0] wq_v[32];
  logic [3:0] wq_o[32];
  bit         wq_e[32];

  function automatic logic [143:0] make_tile(input int seed, input int mode);
    logic [143:0] d;
    for (int v = 0; v < 16; v++) begin
      int x;
      if (mode == 1) x = ((v + seed) % 2 == 0) ? 255 : -255;
      else x = ((seed * 37 + v * 53) % 511) - 255;
      d[v*9 +: 9] = enc(x);
    end
    return d;
  endfunction

  task automatic load_tiles(input int seed, input int mode);
    for (int t = 0; t < 4; t++) begin
      tin_data = make_tile(seed + t, mode);
      tin_valid = 1'b1;
      while (!tin_ready) @(negedge clk);
      @(posedge clk);
      if (t < 3) @(negedge clk);
    end
  endtask

  task automatic drive_w(input int n, input int gap, input bit junk_tiles);
    @(negedge clk);
    if (junk_tiles) tin_data = make_tile(99, 0); else tin_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      w_value = wq_v[k]; w_offset = wq_o[k]; w_empty = wq_e[k];
      w_last = (k == n - 1); w_valid = 1'b1;
      while (!w_ready) @(negedge clk);
      @(negedge clk);
      if (gap > 0) begin
        w_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    w_valid = 1'b0; w_last = 1'b0; w_empty = 1'b0;
    tin_valid = 1'b0;
  endtask

  task automatic run_tile(input int seed, input int mode, input int n, input int gap,
                          input int hold, input bit junk_tiles, input string req);
    int lat;
    cur_req = req;
    load_tiles(seed, mode);
    lat = 0;
    fork
      drive_w(n, gap, junk_tiles);
      begin
        forever begin
          @(negedge clk);
          if (acc_valid) break;
          lat++;
        end
      end
    join
    if (gap == 0) check("R7", lat, (n > 4) ? n : 4, "compute cycles");
    if (hold > 0) cur_req = "R8";
    repeat (hold) @(negedge clk);
    acc_ready = 1'b1;
    @(negedge clk);
    acc_ready = 1'b0;
    check("R8", int'(tin_ready), 1, "tin_ready after transfer");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(tin_ready), 1, "tin_ready in reset");
    check("R1", int'(w_ready), 0, "w_ready in reset");
    check("R1", int'(acc_valid), 0, "acc_valid in reset");
    rst_n = 1'b1;
    run_cmp = 1'b1;
    @(negedge clk);
    check("R1", int'(tin_ready), 1, "tin_ready after reset");

    // R3: one positive weight, no shift.
    wq_v[0] = enc(3); wq_o[0] = 4'h0; wq_e[0] = 0;
    run_tile(1, 0, 1, 0, 0, 0, "R3");

    // R3/R4: one negative weight at the far corner, result held (R8).
    wq_v[0] = enc(-7); wq_o[0] = 4'hF; wq_e[0] = 0;
    run_tile(5, 0, 1, 0, 3, 0, "R3");

    // R4/R5: five weights, one a negative zero; weights offered during load (R2).
    wq_v[0] = enc(12);  wq_o[0] = 4'h0;
    wq_v[1] = enc(-9);  wq_o[1] = 4'h5;
    wq_v[2] = 9'h100;   wq_o[2] = 4'hA;
    wq_v[3] = enc(255); wq_o[3] = 4'hF;
    wq_v[4] = enc(-1);  wq_o[4] = 4'h6;
    for (int k = 0; k < 5; k++) wq_e[k] = 0;
    @(negedge clk);
    w_value = enc(100); w_offset = 4'h3; w_last = 1'b1; w_valid = 1'b1;
    run_tile(9, 0, 5, 0, 0, 0, "R4");

    // R6: position with no weights at all, one empty beat.
    wq_v[0] = enc(77); wq_o[0] = 4'h9; wq_e[0] = 1;
    run_tile(13, 0, 1, 0, 0, 0, "R6");

    // R5: sixteen full-scale weights over every shift.
    for (int k = 0; k < 16; k++) begin
      wq_v[k] = enc((k % 3 == 0) ? -255 : 255); wq_o[k] = 4'(k); wq_e[k] = 0;
    end
    run_tile(2, 1, 16, 0, 0, 0, "R5");

    // R2/R9: gapped weights with an empty beat inside, tiles offered while computing.
    wq_v[0] = enc(40);  wq_o[0] = 4'h4; wq_e[0] = 0;
    wq_v[1] = enc(-50); wq_o[1] = 4'h1; wq_e[1] = 1;
    wq_v[2] = enc(-33); wq_o[2] = 4'hE; wq_e[2] = 0;
    run_tile(21, 0, 3, 2, 2, 1, "R6");

    // Back to back after the gapped case.
    wq_v[0] = enc(-128); wq_o[0] = 4'h7; wq_e[0] = 0;
    wq_v[1] = enc(64);   wq_o[1] = 4'hB; wq_e[1] = 0;
    run_tile(30, 0, 2, 0, 1, 0, "R3");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule